// File: doc/BRIEF.md
# Register-Mapped Serial Peripheral Master

This block is a single-lane serial peripheral master that software drives through a small register window. Software programs the clock divider, the shift length, the bit order, the clock idle level and the edges used to launch and capture data. It then loads a transmit word into the data register and sets the go bit. The block runs one word over `sclk`/`mosi`/`miso`. Once it has finished the word and an optional quiet interval, it raises a completion flag. Software clears that flag by writing it back. The flag can also drive an interrupt line.

The chip select line is not automatic. Software drives it through its own register, which holds an assert bit and an active-level bit. Transmit and receive share one data address: a write loads the transmit word and a read returns the last received word.

The transfer engine is a four-state machine:
- **IDLE** holds `sclk` at the idle level. It moves to LEAD on an accepted go.
- **LEAD** spends one half period at the idle level so the first bit can settle. It moves to SHIFT on its tick, which is also the leading edge of bit 0.
- **SHIFT** runs two half periods per bit. After the last half it moves to GAP when a quiet interval is programmed, and to IDLE otherwise.
- **GAP** waits out the quiet interval and then returns to IDLE. The completion flag is set on that move.

Top module: `spi_reg_master`

## Requirements
- R1: After reset the register window reads as follows: control (address 0x00) reads 0, divider (0x04) reads 0, select (0x08) reads 0 and data (0x10) reads 0. Also `sclk`=0, `ss`=1 and `irq`=0.
- R2: Writing control with bit 0 set while idle starts a transfer, and bit 0 reads 1 until the transfer ends. While a transfer runs, writes to control (other than the flag clear), to the divider and to the data register are ignored, including a second go.
- R3: Control bit 16 becomes 1 in the cycle the transfer ends. A control write with bit 16 set clears it, and a write with bit 16 clear leaves it set.
- R4: `irq` is 1 exactly while control bit 17 (interrupt enable) and bit 16 (completion flag) are both 1.
- R5: Control bit 2 makes `mosi` change on falling `sclk` edges (1) or on rising edges (0). Bit 1 independently makes `miso` be captured on falling edges (1) or on rising edges (0).
- R6: Control bit 10 set shifts the least significant bit first. Clear, it shifts the most significant of the active bits first.
- R7: Outside a transfer `sclk` rests at the value of control bit 31, one cycle after that bit is written.
- R8: Control bits 15:12 (Q) add 2·Q half periods of idle `sclk` after the last bit and before the flag is set.
- R9: Control bits 7:3 (L) set the transfer length N: N=L, and L=0 means 32. Exactly 2·N `sclk` edges occur. The received bits are right-justified in the data register with the bits above N cleared.
- R10: One half period of `sclk` lasts (D+1) clock cycles, where D is the divider register. The flag is set (D+1)·(1+2N+2Q) cycles after the go write.
- R11: In the select register, bit 0 asserts the chip select and bit 2 gives its active level (1 means high). `ss` equals bit 2 when bit 0 is 1 and the inverse of bit 2 otherwise.
- R12: A write to address 0x10 loads the transmit word and leaves the value read back from 0x10, the last received word, unchanged.
- R13: Control bits 9:8 store a word-count value that reads back as written and changes neither the length nor the timing of a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` (combinational) |
| irq | output | 1 | Completion interrupt |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss | output | 1 | Chip select |

## Verification
The main sweep covers every combination of clock idle level, launch edge, capture edge and bit order on a 5-bit word. A serial slave model drives `miso` and captures `mosi`. An error in the leading/trailing edge mapping or in the bit order shows up as a misplaced bit in one direction only, which makes these faults visible.

A second sweep walks the length from 1 to 32 using asymmetric words. This exposes an off-by-one in the bit count, the encoding of 0 as 32, and leftover bits above the right-justified data.

Divider and quiet-interval runs compare the exact completion cycle against the arithmetic formula, which separates half-period errors from gap-count errors. Writes during a busy transfer are checked afterwards through the read-back configuration and the total cycle count.

// File: rtl/spim_pkg.sv
package spim_pkg;

    // Register byte offsets inside the window
    localparam int OFS_CTRL = 'h00;
    localparam int OFS_DIV  = 'h04;
    localparam int OFS_SEL  = 'h08;
    localparam int OFS_DATA = 'h10;

    // Maximum word size of one transfer
    localparam int WORD_W = 32;

    typedef struct packed {
        logic       cpol;     // idle level of sclk
        logic       ie;       // interrupt enable
        logic [3:0] idle;     // quiet interval in sclk periods
        logic       lsb;      // lsb-first order
        logic [1:0] wcnt;     // stored word-count value
        logic [4:0] blen;     // bit length, 0 encodes 32
        logic       tx_fall;  // launch on falling edge
        logic       rx_fall;  // capture on falling edge
    } cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SHIFT,
        ST_GAP
    } seq_state_t;

    function automatic logic [5:0] nbits_of(input logic [4:0] blen);
        return (blen == 5'd0) ? 6'd32 : {1'b0, blen};
    endfunction

endpackage

// File: rtl/spim_regs.sv
module spim_regs
    import spim_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DIV_W  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [31:0]         bus_wdata,
    input  logic                busy,
    input  logic                xfer_end,
    input  logic [WORD_W-1:0]   rx_word,
    output cfg_t                cfg,
    output logic [DIV_W-1:0]    div,
    output logic                sel_on,
    output logic                sel_high,
    output logic [WORD_W-1:0]   tx_word,
    output logic                start,
    output logic                done,
    output logic [31:0]         bus_rdata
);

    logic hit_ctrl, hit_div, hit_sel, hit_data;

    assign hit_ctrl = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
    assign hit_div  = bus_wr && (bus_addr == ADDR_W'(OFS_DIV));
    assign hit_sel  = bus_wr && (bus_addr == ADDR_W'(OFS_SEL));
    assign hit_data = bus_wr && (bus_addr == ADDR_W'(OFS_DATA));

    // A go request is only honoured from idle
    assign start = hit_ctrl && bus_wdata[0] && !busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg      <= '0;
            div      <= '0;
            sel_on   <= 1'b0;
            sel_high <= 1'b0;
            tx_word  <= '0;
            done     <= 1'b0;
        end else begin
            if (hit_ctrl && !busy) begin
                cfg.cpol    <= bus_wdata[31];
                cfg.ie      <= bus_wdata[17];
                cfg.idle    <= bus_wdata[15:12];
                cfg.lsb     <= bus_wdata[10];
                cfg.wcnt    <= bus_wdata[9:8];
                cfg.blen    <= bus_wdata[7:3];
                cfg.tx_fall <= bus_wdata[2];
                cfg.rx_fall <= bus_wdata[1];
            end
            if (hit_div && !busy) begin
                div <= bus_wdata[DIV_W-1:0];
            end
            if (hit_data && !busy) begin
                tx_word <= bus_wdata[WORD_W-1:0];
            end
            if (hit_sel) begin
                sel_on   <= bus_wdata[0];
                sel_high <= bus_wdata[2];
            end
            if (xfer_end) begin
                done <= 1'b1;
            end else if (hit_ctrl && bus_wdata[16]) begin
                done <= 1'b0;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADDR_W'(OFS_CTRL): bus_rdata = {cfg.cpol, 13'd0, cfg.ie, done, cfg.idle,
                                            1'b0, cfg.lsb, cfg.wcnt, cfg.blen,
                                            cfg.tx_fall, cfg.rx_fall, busy};
            ADDR_W'(OFS_DIV):  bus_rdata = 32'(div);
            ADDR_W'(OFS_SEL):  bus_rdata = {29'd0, sel_high, 1'b0, sel_on};
            ADDR_W'(OFS_DATA): bus_rdata = 32'(rx_word);
            default:           bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/spim_seq.sv
module spim_seq
    import spim_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             cpol,
    input  logic             tx_fall,
    input  logic             rx_fall,
    input  logic [3:0]       idle,
    input  logic [4:0]       blen,
    input  logic [DIV_W-1:0] div,
    output logic             busy,
    output logic             sclk,
    output logic             tx_step,
    output logic             rx_step,
    output logic             xfer_end
);

    localparam int HALF_W = 7;   // up to 64 half periods
    localparam int GAP_W  = 5;   // up to 30 gap half periods

    seq_state_t          state, nxt;
    logic [DIV_W-1:0]    hc;
    logic [HALF_W-1:0]   half;
    logic [GAP_W-1:0]    gap;
    logic                sclk_q;
    logic                tick, at_last, mid_edge, next_lead, tx_lead, rx_lead;
    logic [HALF_W-1:0]   last_half;

    assign tick      = (hc == '0);
    assign last_half = {nbits_of(blen), 1'b0} - HALF_W'(1);
    assign at_last   = (half == last_half);
    // leading edge = sclk leaves its idle level
    assign tx_lead   = (tx_fall == cpol);
    assign rx_lead   = (rx_fall == cpol);
    assign mid_edge  = (state == ST_SHIFT) && tick && !at_last;
    assign next_lead = half[0];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (start) nxt = ST_LEAD;
            ST_LEAD:  if (tick) nxt = ST_SHIFT;
            ST_SHIFT: if (tick && at_last) nxt = (idle == 4'd0) ? ST_IDLE : ST_GAP;
            ST_GAP:   if (tick && gap == '0) nxt = ST_IDLE;
        endcase
    end

    // per-edge strobes
    always_comb begin
        tx_step  = mid_edge && (next_lead == tx_lead);
        rx_step  = ((state == ST_LEAD) && tick && rx_lead) ||
                   (mid_edge && (next_lead == rx_lead));
        xfer_end = ((state == ST_SHIFT) && tick && at_last && (idle == 4'd0)) ||
                   ((state == ST_GAP) && tick && (gap == '0));
    end

    // outputs and timers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hc     <= '0;
            half   <= '0;
            gap    <= '0;
            sclk_q <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    sclk_q <= cpol;
                    hc     <= div;
                    half   <= '0;
                    gap    <= '0;
                end
                ST_LEAD: begin
                    if (tick) begin
                        hc     <= div;
                        half   <= '0;
                        sclk_q <= ~cpol;
                    end else begin
                        hc     <= hc - 1'b1;
                        sclk_q <= cpol;
                    end
                end
                ST_SHIFT: begin
                    if (tick) begin
                        hc  <= div;
                        gap <= {idle, 1'b0} - GAP_W'(1);
                        if (!at_last) begin
                            half   <= half + 1'b1;
                            sclk_q <= ~sclk_q;
                        end
                    end else begin
                        hc <= hc - 1'b1;
                    end
                end
                ST_GAP: begin
                    if (tick) begin
                        hc  <= div;
                        gap <= gap - 1'b1;
                    end else begin
                        hc <= hc - 1'b1;
                    end
                end
            endcase
        end
    end

    assign busy = (state != ST_IDLE);
    assign sclk = sclk_q;

endmodule

// File: rtl/spim_shift.sv
module spim_shift
    import spim_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              lsb,
    input  logic [4:0]        blen,
    input  logic              tx_step,
    input  logic              rx_step,
    input  logic              miso,
    output logic              mosi,
    output logic [WORD_W-1:0] rx_word
);

    logic [4:0] tx_idx, rx_idx, tx_pos, rx_pos, top_idx;
    logic [5:0] nb;

    assign nb      = nbits_of(blen);
    assign top_idx = 5'(nb - 6'd1);

    // time index -> bit position
    assign tx_pos = lsb ? tx_idx : 5'(nb - 6'd1 - {1'b0, tx_idx});
    assign rx_pos = lsb ? rx_idx : 5'(nb - 6'd1 - {1'b0, rx_idx});

    assign mosi = tx_word[tx_pos];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_idx  <= '0;
            rx_idx  <= '0;
            rx_word <= '0;
        end else if (load) begin
            tx_idx  <= '0;
            rx_idx  <= '0;
            rx_word <= '0;
        end else begin
            if (tx_step && tx_idx != top_idx) begin
                tx_idx <= tx_idx + 1'b1;
            end
            if (rx_step) begin
                rx_word[rx_pos] <= miso;
                if (rx_idx != top_idx) rx_idx <= rx_idx + 1'b1;
            end
        end
    end

endmodule

// File: rtl/spi_reg_master.sv
module spi_reg_master
    import spim_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DIV_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic              ss
);

    cfg_t               cfg;
    logic [DIV_W-1:0]   div;
    logic [WORD_W-1:0]  tx_word, rx_word;
    logic               sel_on, sel_high, start, done_flag, busy;
    logic               tx_step, rx_step, xfer_end;

    spim_regs #(.ADDR_W(ADDR_W), .DIV_W(DIV_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .busy      (busy),
        .xfer_end  (xfer_end),
        .rx_word   (rx_word),
        .cfg       (cfg),
        .div       (div),
        .sel_on    (sel_on),
        .sel_high  (sel_high),
        .tx_word   (tx_word),
        .start     (start),
        .done      (done_flag),
        .bus_rdata (bus_rdata)
    );

    spim_seq #(.DIV_W(DIV_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .cpol     (cfg.cpol),
        .tx_fall  (cfg.tx_fall),
        .rx_fall  (cfg.rx_fall),
        .idle     (cfg.idle),
        .blen     (cfg.blen),
        .div      (div),
        .busy     (busy),
        .sclk     (sclk),
        .tx_step  (tx_step),
        .rx_step  (rx_step),
        .xfer_end (xfer_end)
    );

    spim_shift u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (start),
        .tx_word (tx_word),
        .lsb     (cfg.lsb),
        .blen    (cfg.blen),
        .tx_step (tx_step),
        .rx_step (rx_step),
        .miso    (miso),
        .mosi    (mosi),
        .rx_word (rx_word)
    );

    assign irq = done_flag & cfg.ie;
    assign ss  = sel_on ? sel_high : ~sel_high;

endmodule

// File: rtl/spim_chk.sv
module spim_chk
    import spim_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              busy,
    input logic              done,
    input logic              sclk,
    input logic              ss,
    input cfg_t              cfg
);

    // R3: the flag rises only as a transfer ends
    assert_done_at_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(busy) && !busy));

    // R2: a transfer begins only after a go write
    assert_go_starts_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(bus_wr && (bus_addr == ADDR_W'(OFS_CTRL)) && bus_wdata[0]));

    // R2: configuration frozen during a transfer
    assert_cfg_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cfg));

    // R7: idle clock level follows the polarity bit
    assert_sclk_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy)) |-> (sclk == $past(cfg.cpol)));

    // R11: chip select moves only after a select write
    assert_ss_by_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ss) |-> $past(bus_wr && (bus_addr == ADDR_W'(OFS_SEL))));

endmodule

bind spi_reg_master spim_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .busy      (busy),
    .done      (done_flag),
    .sclk      (sclk),
    .ss        (ss),
    .cfg       (cfg)
);

// File: tb/spi_reg_master_tb_top.sv
module spi_reg_master_tb_top;

    localparam int ADDR_W = 5;
    localparam logic [ADDR_W-1:0] A_CTRL = 5'h00;
    localparam logic [ADDR_W-1:0] A_DIV  = 5'h04;
    localparam logic [ADDR_W-1:0] A_SEL  = 5'h08;
    localparam logic [ADDR_W-1:0] A_DATA = 5'h10;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              bus_wr;
    logic [ADDR_W-1:0] bus_addr;
    logic [31:0]       bus_wdata;
    logic [31:0]       bus_rdata;
    logic              irq, sclk, mosi, miso, ss;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // slave model state
    bit          active = 1'b0;
    bit          cp_g, tl_g, rl_g, ls_g, lead_now;
    int          nb_g = 1;
    int          tk, rk, edges;
    logic [31:0] sbits, cap;

    always #4ns clk = ~clk;

    spi_reg_master #(.ADDR_W(ADDR_W), .DIV_W(16)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq),
        .sclk      (sclk),
        .mosi      (mosi),
        .miso      (miso),
        .ss        (ss)
    );

    function automatic int pidx(input int k);
        return ls_g ? k : nb_g - 1 - k;
    endfunction

    // serial slave: feeds miso after each capture edge, samples mosi on the other edge type
    always @(sclk) begin
        if (active) begin
            edges++;
            lead_now = (sclk != cp_g);
            if (lead_now == rl_g) begin
                rk++;
                miso = (rk < nb_g) ? sbits[rk] : 1'b0;
            end
            if (lead_now != tl_g) begin
                if (tk < nb_g) cap[pidx(tk)] = mosi;
                tk++;
            end
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a;
        #1ns v = bus_rdata;
    endtask

    // waits from the negedge after the go write until the flag reads 1
    task automatic wait_done(output int cyc);
        cyc = 0;
        bus_addr = A_CTRL;
        #1ns;
        while (!bus_rdata[16]) begin
            @(negedge clk);
            cyc++;
            #1ns;
        end
    endtask

    task automatic run(input bit cp, input bit tf, input bit rf, input bit ls, input int nb,
                       input int dv, input int idl, input logic [31:0] txw, input logic [31:0] rxw,
                       input bit ie, input logic [1:0] wc, input string req);
        logic [31:0] mask, cfgw, v;
        int cyc, exp_cyc;
        mask = (nb == 32) ? 32'hFFFF_FFFF : ((32'd1 << nb) - 32'd1);
        cfgw = {cp, 13'd0, ie, 1'b0, 4'(idl), 1'b0, ls, wc, 5'(nb), tf, rf, 1'b0};
        wr(A_DIV, 32'(dv));
        wr(A_DATA, txw);
        wr(A_CTRL, cfgw | 32'h0001_0000);
        repeat (2) @(negedge clk);
        cp_g = cp; ls_g = ls; nb_g = nb;
        tl_g = (tf == cp); rl_g = (rf == cp);
        sbits = '0;
        for (int k = 0; k < nb; k++) sbits[k] = rxw[pidx(k)];
        cap = '0; tk = 0; rk = 0; edges = 0;
        miso = sbits[0];
        active = 1'b1;
        wr(A_CTRL, cfgw | 32'h1);
        wait_done(cyc);
        active = 1'b0;
        exp_cyc = (dv + 1) * (1 + 2 * nb + 2 * idl);
        chk("R10 R8", "completion cycle", 32'(cyc), 32'(exp_cyc));
        chk("R9", "sclk edge count", 32'(edges), 32'(2 * nb));
        chk(req, "mosi word", cap, txw & mask);
        rd(A_DATA, v);
        chk(req, "received word", v, rxw & mask);
    endtask

    initial begin
        #(8ns * 200000);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] cfg_a;
        int cyc;
        rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; miso = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(A_CTRL, v); chk("R1", "control", v, 32'h0);
        rd(A_DIV, v);  chk("R1", "divider", v, 32'h0);
        rd(A_SEL, v);  chk("R1", "select", v, 32'h0);
        rd(A_DATA, v); chk("R1", "data", v, 32'h0);
        chk("R1", "sclk", 32'(sclk), 32'h0);
        chk("R1", "ss", 32'(ss), 32'h1);
        chk("R1", "irq", 32'(irq), 32'h0);

        // R11 chip select combinations
        for (int s = 0; s < 4; s++) begin
            wr(A_SEL, {29'd0, s[1], 1'b0, s[0]});
            @(negedge clk);
            chk("R11", "ss level", 32'(ss), 32'(s[0] ? s[1] : !s[1]));
            rd(A_SEL, v);
            chk("R11", "select readback", v, {29'd0, s[1], 1'b0, s[0]});
        end

        // R7 idle level
        wr(A_CTRL, 32'h8000_0000);
        @(negedge clk);
        chk("R7", "sclk idle high", 32'(sclk), 32'h1);
        wr(A_CTRL, 32'h0);
        @(negedge clk);
        chk("R7", "sclk idle low", 32'(sclk), 32'h0);

        // R5 R6 sweep over polarity, launch edge, capture edge, order
        for (int c = 0; c < 16; c++) begin
            run(c[3], c[2], c[1], c[0], 5, 1, 0,
                32'h16 ^ 32'(c * 3), 32'h0B ^ 32'(c * 5), 1'b0, 2'd0, "R5 R6");
        end

        // R9 lengths 1..32
        for (int n = 1; n <= 32; n++) begin
            run(n[0], n[1], n[2], n[0] ^ n[3], n, 0, 0,
                32'hC3A5_96E1 ^ (32'(n) * 32'h0101_0101),
                32'h5A3C_E187 + 32'(n * 77), 1'b0, 2'd0, "R9");
        end

        // R10 longer half period
        run(1'b0, 1'b1, 1'b0, 1'b0, 8, 3, 0, 32'hA7, 32'h3C, 1'b0, 2'd0, "R10");

        // R8 quiet interval
        run(1'b1, 1'b0, 1'b1, 1'b1, 4, 1, 3, 32'h9, 32'h6, 1'b0, 2'd0, "R8");
        run(1'b0, 1'b0, 1'b0, 1'b0, 2, 0, 15, 32'h2, 32'h1, 1'b0, 2'd0, "R8");

        // R12 data write leaves read value (last rx = 1)
        wr(A_DATA, 32'hFFFF_1234);
        rd(A_DATA, v);
        chk("R12", "rx after tx write", v, 32'h1);

        // R4 flag without enable
        chk("R4", "irq with enable clear", 32'(irq), 32'h0);
        // R3 write-back clear
        wr(A_CTRL, 32'h0000_0008);
        rd(A_CTRL, v);
        chk("R3", "flag kept by write of 0", 32'(v[16]), 32'h1);
        wr(A_CTRL, 32'h0001_0008);
        rd(A_CTRL, v);
        chk("R3", "flag cleared by write of 1", 32'(v[16]), 32'h0);

        // R4 with enable
        run(1'b0, 1'b1, 1'b0, 1'b0, 3, 0, 0, 32'h5, 32'h3, 1'b1, 2'd0, "R4");
        @(negedge clk);
        chk("R4", "irq with flag and enable", 32'(irq), 32'h1);
        wr(A_CTRL, 32'h0003_0018);
        @(negedge clk);
        chk("R4", "irq after clear", 32'(irq), 32'h0);

        // R13 word-count field
        run(1'b0, 1'b1, 1'b0, 1'b1, 6, 1, 0, 32'h2D, 32'h1A, 1'b0, 2'd3, "R13");
        rd(A_CTRL, v);
        chk("R13", "word-count readback", v & 32'h300, 32'h300);

        // R2 busy protection
        wr(A_DIV, 32'd3);
        cfg_a = {1'b0, 13'd0, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0, 2'd0, 5'd16, 1'b1, 1'b0, 1'b0};
        wr(A_CTRL, cfg_a | 32'h0001_0000);
        wr(A_CTRL, cfg_a | 32'h1);
        rd(A_CTRL, v);
        chk("R2", "busy bit during transfer", 32'(v[0]), 32'h1);
        wr(A_CTRL, 32'h8000_F4C7);
        wr(A_DIV, 32'd7);
        wr(A_DATA, 32'hFFFF_FFFF);
        @(negedge clk);
        wait_done(cyc);
        chk("R2", "total cycles from first go", 32'(cyc + 8), 32'(4 * 33));
        rd(A_CTRL, v);
        chk("R2", "config unchanged", v & ~32'h0001_0001, cfg_a);
        chk("R2", "busy bit after end", 32'(v[0]), 32'h0);
        rd(A_DIV, v);
        chk("R2", "divider unchanged", v, 32'd3);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule